// File: doc/BRIEF.md
# Serial Configuration EEPROM Word Reader

This block fetches 16-bit words from a three-wire serial EEPROM holding 64 words. It drives chip select, a serial clock and a command/address line into the device, and it reads the device's data line back. A host asks for one word by giving a 6-bit word address and a one-cycle start strobe. The block sends the read command and the address, clocks in sixteen data bits and returns the word together with a one-cycle done pulse. The length of each serial clock phase is set by a programmable divider input, counted in system clocks.

A boot sequencer sits on top of the word engine. On its own strobe it reads every word of the device, lowest address first, into a local image. When the last word has arrived it decides whether a device is present. A first word that is all ones or all zeros means the device is blank or missing; otherwise the block takes a 6-byte station address from the image, starting at byte 20.

Top module: `eeprom_word_reader`

## Requirements
- R1: After reset, eeCs, eeSk, eeDi, rdDone, busy, bootDone and noEeprom are 0, and rdData and stationAddr are 0.
- R2: A start accepted at a clock edge raises eeCs in the next cycle, and eeCs stays high with eeSk low for one phase before the first bit. A phase is phaseLen system clocks long.
- R3: The block sends nine bits on eeDi: the read command 1, 1, 0 in that order, then the word address MSB first. Each bit is held for three phases, with eeSk low, then high, then low.
- R4: Sixteen input bits follow. Each has the same three phases, with eeDi held low. eeDo is sampled in the last system clock of the high phase and shifted in MSB first.
- R5: In the cycle after the last input bit, eeCs is low and rdDone is high for one cycle. rdData holds the word from that cycle until the next accepted start.
- R6: busy is high from the cycle after an accepted start through the rdDone cycle. A rdStart while busy is high is ignored.
- R7: phaseLen is captured when a read is accepted, and a value of 0 counts as 1. A change to phaseLen during a read has no effect on that read.
- R8: A bootStart while the block is idle reads words 0 to 63 in ascending order. Before each read there is one cycle with eeCs low, and rdDone pulses for every word. busy stays high for the whole sequence, and rdStart is ignored during it.
- R9: bootDone pulses for one cycle, in the cycle after the rdDone of word 63. busy is low in that cycle.
- R10: When word 0 is neither 0xFFFF nor 0x0000, noEeprom is 0 and stationAddr is {word12, word11, word10}. This is image bytes 20 to 25 with words stored low byte first, so stationAddr[7:0] is byte 20. The values are updated with bootDone and then held.
- R11: When word 0 is 0xFFFF or 0x0000, noEeprom is 1 and stationAddr is 0, updated with bootDone.
- R12: When rdStart and bootStart are both high in an idle cycle, the boot sequence runs and the single read does not. A bootStart while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| phaseLen | input | 16 | System clocks per serial phase (0 acts as 1) |
| rdStart | input | 1 | One-cycle request for a single word read |
| rdAddr | input | 6 | Word address for the single read |
| rdData | output | 16 | Last word read |
| rdDone | output | 1 | One-cycle pulse when a word read ends |
| busy | output | 1 | A read or the boot sequence is in progress |
| bootStart | input | 1 | One-cycle request to load the full image |
| bootDone | output | 1 | One-cycle pulse when the image load ends |
| noEeprom | output | 1 | Word 0 was blank, so no device is present |
| stationAddr | output | 48 | Station address taken from the image |
| eeCs | output | 1 | EEPROM chip select |
| eeSk | output | 1 | EEPROM serial clock |
| eeDi | output | 1 | Command and address line into the EEPROM |
| eeDo | input | 1 | Data line from the EEPROM |

## Verification
The hardest conditions to reach are the ones that depend on one exact cycle. One is a rdStart landing in the very cycle rdDone is high. Another is a rdStart in the cycle bootDone is high, where it must be accepted. A third is a phaseLen change partway through a read. The bench schedules each read as a queue of expected per-cycle states, so it knows in advance which cycle comes next. It raises the strobe when only the done entry, or only the boot-finished entry, is left in the queue. The bench plays the EEPROM by driving eeDo from that same queue, and it runs full image loads with a blank first word of each kind.

// File: rtl/eeprom_rd_pkg.sv
package eeprom_rd_pkg;
  localparam int EE_ADDR_W = 6;
  localparam int EE_DATA_W = 16;
  localparam int EE_OPC_W  = 3;
  localparam logic [EE_OPC_W-1:0] EE_READ_OPC = 3'b110;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT,
    ST_DONE
  } xferState_t;

  typedef struct packed {
    logic load;      // capture command+address, clear input word
    logic shiftOut;  // advance outgoing bit
    logic sample;    // shift in eeDo
    logic driveOut;  // eeDi carries the outgoing bit
  } xferStrobe_t;
endpackage

// File: rtl/eeprom_rd_ctrl.sv
module eeprom_rd_ctrl
  import eeprom_rd_pkg::*;
#(
  parameter int PHASE_W  = 16,
  parameter int OUT_BITS = EE_OPC_W + EE_ADDR_W,
  parameter int IN_BITS  = EE_DATA_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PHASE_W-1:0] phaseLen,
  input  logic               start,
  output xferStrobe_t        strobe,
  output logic               eeCs,
  output logic               eeSk,
  output logic               xferBusy,
  output logic               xferDone,
  output logic               ctrlIdle
);
  localparam int TOTAL_BITS = OUT_BITS + IN_BITS;
  localparam int BIT_W      = $clog2(TOTAL_BITS);

  xferState_t         state;
  logic [PHASE_W-1:0] divCnt;
  logic [PHASE_W-1:0] phaseLenQ;
  logic [1:0]         phase;
  logic [BIT_W-1:0]   bitIdx;
  logic               lastCyc;
  logic               isOutBit;

  assign lastCyc  = (divCnt == phaseLenQ - PHASE_W'(1));
  assign isOutBit = (bitIdx < BIT_W'(OUT_BITS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      divCnt    <= '0;
      phaseLenQ <= PHASE_W'(1);
      phase     <= 2'd0;
      bitIdx    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state     <= ST_SETUP;
            divCnt    <= '0;
            phaseLenQ <= (phaseLen == '0) ? PHASE_W'(1) : phaseLen;
          end
        end
        ST_SETUP: begin
          if (lastCyc) begin
            state  <= ST_SHIFT;
            divCnt <= '0;
            phase  <= 2'd0;
            bitIdx <= '0;
          end else begin
            divCnt <= divCnt + PHASE_W'(1);
          end
        end
        ST_SHIFT: begin
          if (lastCyc) begin
            divCnt <= '0;
            if (phase == 2'd2) begin
              phase <= 2'd0;
              if (bitIdx == BIT_W'(TOTAL_BITS - 1)) state <= ST_DONE;
              else bitIdx <= bitIdx + BIT_W'(1);
            end else begin
              phase <= phase + 2'd1;
            end
          end else begin
            divCnt <= divCnt + PHASE_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.load     = (state == ST_IDLE) && start;
    strobe.shiftOut = (state == ST_SHIFT) && lastCyc && (phase == 2'd2) && isOutBit;
    strobe.sample   = (state == ST_SHIFT) && lastCyc && (phase == 2'd1) && !isOutBit;
    strobe.driveOut = (state == ST_SHIFT) && isOutBit;
  end

  assign eeCs     = (state == ST_SETUP) || (state == ST_SHIFT);
  assign eeSk     = (state == ST_SHIFT) && (phase == 2'd1);
  assign xferBusy = (state != ST_IDLE);
  assign xferDone = (state == ST_DONE);
  assign ctrlIdle = (state == ST_IDLE);

  // R3
  sk_framed_chk: assert property (@(posedge clk) disable iff (!rstN) eeSk |-> eeCs);
  // R4
  sample_in_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sample |-> (eeSk && !strobe.driveOut));
  // R5
  cs_drop_chk: assert property (@(posedge clk) disable iff (!rstN) $fell(eeCs) |-> xferDone);
  // R6
  done_then_idle_chk: assert property (@(posedge clk) disable iff (!rstN) xferDone |=> ctrlIdle);
endmodule

// File: rtl/eeprom_rd_dpath.sv
module eeprom_rd_dpath
  import eeprom_rd_pkg::*;
#(
  parameter int ADDR_W = EE_ADDR_W,
  parameter int DATA_W = EE_DATA_W,
  parameter int OPC_W  = EE_OPC_W,
  parameter logic [OPC_W-1:0] OPCODE = EE_READ_OPC
) (
  input  logic              clk,
  input  logic              rstN,
  input  xferStrobe_t       strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic              eeDo,
  output logic              eeDi,
  output logic [DATA_W-1:0] word
);
  localparam int OUT_BITS = OPC_W + ADDR_W;

  logic [OUT_BITS-1:0] outReg;
  logic [DATA_W-1:0]   inReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg <= '0;
      inReg  <= '0;
    end else if (strobe.load) begin
      outReg <= {OPCODE, addr};
      inReg  <= '0;
    end else begin
      if (strobe.shiftOut) outReg <= {outReg[OUT_BITS-2:0], 1'b0};
      if (strobe.sample)   inReg  <= {inReg[DATA_W-2:0], eeDo};
    end
  end

  assign eeDi = strobe.driveOut & outReg[OUT_BITS-1];
  assign word = inReg;

  // R4
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.sample && strobe.shiftOut));
endmodule

// File: rtl/eeprom_rd_boot.sv
module eeprom_rd_boot
  import eeprom_rd_pkg::*;
#(
  parameter int ADDR_W      = EE_ADDR_W,
  parameter int DATA_W      = EE_DATA_W,
  parameter int STATION_OFF = 20,
  parameter int MAC_BYTES   = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   bootStart,
  input  logic                   ctrlIdle,
  input  logic                   xferDone,
  input  logic [DATA_W-1:0]      wordIn,
  output logic                   bootActive,
  output logic                   bootIssue,
  output logic [ADDR_W-1:0]      bootAddr,
  output logic                   bootDone,
  output logic                   noEeprom,
  output logic [8*MAC_BYTES-1:0] stationAddr
);
  localparam int WORDS = 1 << ADDR_W;
  localparam int BPW   = DATA_W / 8;

  logic [DATA_W-1:0]      image [WORDS];
  logic [ADDR_W-1:0]      wordIdx;
  logic [8*MAC_BYTES-1:0] stationNext;
  logic                   blank;

  for (genvar j = 0; j < MAC_BYTES; j++) begin : g_mac
    localparam int BI = STATION_OFF + j;
    assign stationNext[8*j +: 8] = image[BI / BPW][(BI % BPW)*8 +: 8];
  end

  assign blank = (image[0] == '1) || (image[0] == '0);

  always_ff @(posedge clk) begin
    if (bootActive && xferDone) image[wordIdx] <= wordIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bootActive  <= 1'b0;
      wordIdx     <= '0;
      bootDone    <= 1'b0;
      noEeprom    <= 1'b0;
      stationAddr <= '0;
    end else begin
      bootDone <= 1'b0;
      if (!bootActive && bootStart && ctrlIdle) begin
        bootActive <= 1'b1;
        wordIdx    <= '0;
      end else if (bootActive && xferDone) begin
        if (wordIdx == ADDR_W'(WORDS - 1)) begin
          bootActive  <= 1'b0;
          bootDone    <= 1'b1;
          noEeprom    <= blank;
          stationAddr <= blank ? '0 : stationNext;
        end else begin
          wordIdx <= wordIdx + ADDR_W'(1);
        end
      end
    end
  end

  assign bootIssue = bootActive && ctrlIdle;
  assign bootAddr  = wordIdx;

  // R9
  boot_done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    bootDone |-> (ctrlIdle && !bootActive));
  // R9
  boot_done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) bootDone |=> !bootDone);
  // R8
  boot_one_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    bootIssue |=> !bootIssue);
endmodule

// File: rtl/eeprom_word_reader.sv
module eeprom_word_reader
  import eeprom_rd_pkg::*;
#(
  parameter int PHASE_W     = 16,
  parameter int ADDR_W      = EE_ADDR_W,
  parameter int DATA_W      = EE_DATA_W,
  parameter int STATION_OFF = 20,
  parameter int MAC_BYTES   = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [PHASE_W-1:0]     phaseLen,
  input  logic                   rdStart,
  input  logic [ADDR_W-1:0]      rdAddr,
  output logic [DATA_W-1:0]      rdData,
  output logic                   rdDone,
  output logic                   busy,
  input  logic                   bootStart,
  output logic                   bootDone,
  output logic                   noEeprom,
  output logic [8*MAC_BYTES-1:0] stationAddr,
  output logic                   eeCs,
  output logic                   eeSk,
  output logic                   eeDi,
  input  logic                   eeDo
);
  xferStrobe_t       strobe;
  logic              xferBusy, ctrlIdle, ctrlStart;
  logic              bootActive, bootIssue;
  logic [ADDR_W-1:0] bootAddr, selAddr;

  assign ctrlStart = bootActive ? bootIssue : (rdStart && !bootStart);
  assign selAddr   = bootActive ? bootAddr : rdAddr;
  assign busy      = xferBusy || bootActive;

  eeprom_rd_ctrl #(
    .PHASE_W (PHASE_W),
    .OUT_BITS(EE_OPC_W + ADDR_W),
    .IN_BITS (DATA_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .phaseLen(phaseLen), .start(ctrlStart),
    .strobe(strobe), .eeCs(eeCs), .eeSk(eeSk), .xferBusy(xferBusy),
    .xferDone(rdDone), .ctrlIdle(ctrlIdle)
  );

  eeprom_rd_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OPC_W(EE_OPC_W), .OPCODE(EE_READ_OPC)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addr(selAddr),
    .eeDo(eeDo), .eeDi(eeDi), .word(rdData)
  );

  eeprom_rd_boot #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STATION_OFF(STATION_OFF), .MAC_BYTES(MAC_BYTES)
  ) u_boot (
    .clk(clk), .rstN(rstN), .bootStart(bootStart), .ctrlIdle(ctrlIdle),
    .xferDone(rdDone), .wordIn(rdData), .bootActive(bootActive),
    .bootIssue(bootIssue), .bootAddr(bootAddr), .bootDone(bootDone),
    .noEeprom(noEeprom), .stationAddr(stationAddr)
  );

  // R6
  busy_on_cs_chk: assert property (@(posedge clk) disable iff (!rstN) eeCs |-> busy);
endmodule

// File: tb/test_eeprom_word_reader.sv
module test_eeprom_word_reader;
  timeunit 1ns;
  timeprecision 100ps;

  typedef struct {
    bit cs, sk, di, done, busy, bdone, doBit, chkData;
    logic [15:0] data;
    string tag;
  } exp_t;

  logic        clk = 0;
  logic        rstN = 0;
  logic [15:0] phaseLen = 16'd1;
  logic        rdStart = 0;
  logic [5:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic        rdDone, busy;
  logic        bootStart = 0;
  logic        bootDone, noEeprom;
  logic [47:0] stationAddr;
  logic        eeCs, eeSk, eeDi;
  logic        eeDo = 0;

  always #2.5ns clk = ~clk;

  eeprom_word_reader i_eeprom_word_reader (
    .clk(clk), .rstN(rstN), .phaseLen(phaseLen), .rdStart(rdStart), .rdAddr(rdAddr),
    .rdData(rdData), .rdDone(rdDone), .busy(busy), .bootStart(bootStart),
    .bootDone(bootDone), .noEeprom(noEeprom), .stationAddr(stationAddr),
    .eeCs(eeCs), .eeSk(eeSk), .eeDi(eeDi), .eeDo(eeDo)
  );

  exp_t        q[$];
  int          checks = 0, failures = 0;
  logic [15:0] img [64];
  logic [15:0] heldData = '0;
  logic [47:0] modStation = '0;
  bit          modNoEe = 0;
  bit          wantRd = 0, wantBoot = 0;
  logic [5:0]  wantAddr = '0;
  int          curP = 1;
  string       curTest = "R1 reset state";

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s [%s] %s: actual=%0h expected=%0h", tag, curTest, what, act, expv);
    end
  endtask

  function automatic exp_t mk(bit cs, bit sk, bit di, bit busyV, string tag);
    exp_t e;
    e.cs = cs; e.sk = sk; e.di = di; e.busy = busyV; e.tag = tag;
    e.done = 0; e.bdone = 0; e.doBit = 0; e.chkData = 0; e.data = '0;
    return e;
  endfunction

  function automatic void pushXfer(logic [5:0] addr, logic [15:0] data, int p);
    logic [8:0] cmd = {3'b110, addr};
    exp_t e;
    for (int c = 0; c < p; c++) q.push_back(mk(1, 0, 0, 1, "R2"));
    for (int b = 0; b < 25; b++) begin
      for (int ph = 0; ph < 3; ph++) begin
        for (int c = 0; c < p; c++) begin
          e = mk(1, ph == 1, (b < 9) ? cmd[8-b] : 1'b0, 1, (b < 9) ? "R3" : "R4");
          e.doBit = (b >= 9) ? data[15-(b-9)] : 1'b0;
          q.push_back(e);
        end
      end
    end
    e = mk(0, 0, 0, 1, "R5");
    e.done = 1; e.chkData = 1; e.data = data;
    q.push_back(e);
  endfunction

  function automatic void pushBoot(int p);
    exp_t e;
    for (int w = 0; w < 64; w++) begin
      e = mk(0, 0, 0, 1, "R8");
      e.chkData = 1;
      q.push_back(e);
      pushXfer(6'(w), img[w], p);
    end
    e = mk(0, 0, 0, 0, "R9");
    e.bdone = 1; e.chkData = 1;
    q.push_back(e);
  endfunction

  task automatic cyc();
    exp_t e;
    int p;
    @(negedge clk);
    if (q.size() > 0) e = q.pop_front();
    else begin
      e = mk(0, 0, 0, 0, "R6");
      e.chkData = 1;
    end
    if (e.done) heldData = e.data;
    if (e.bdone) begin
      modNoEe    = (img[0] == 16'hFFFF) || (img[0] == 16'h0000);
      modStation = modNoEe ? 48'h0 : {img[12], img[11], img[10]};
    end
    chk(eeCs === e.cs, e.tag, "eeCs", 64'(eeCs), 64'(e.cs));
    chk(eeSk === e.sk, e.tag, "eeSk", 64'(eeSk), 64'(e.sk));
    chk(eeDi === e.di, e.tag, "eeDi", 64'(eeDi), 64'(e.di));
    chk(rdDone === e.done, e.tag, "rdDone", 64'(rdDone), 64'(e.done));
    chk(busy === e.busy, "R6", "busy", 64'(busy), 64'(e.busy));
    chk(bootDone === e.bdone, "R9", "bootDone", 64'(bootDone), 64'(e.bdone));
    if (e.chkData) chk(rdData === heldData, "R5", "rdData", 64'(rdData), 64'(heldData));
    chk(noEeprom === modNoEe, "R11", "noEeprom", 64'(noEeprom), 64'(modNoEe));
    chk(stationAddr === modStation, "R10", "stationAddr", 64'(stationAddr), 64'(modStation));
    eeDo = e.doBit;
    rdStart   = wantRd;
    bootStart = wantBoot;
    rdAddr    = wantAddr;
    phaseLen  = 16'(curP);
    p = (curP == 0) ? 1 : curP;
    if (!e.busy && rstN) begin
      if (wantBoot) pushBoot(p);
      else if (wantRd) pushXfer(wantAddr, img[wantAddr], p);
    end
    wantRd = 0;
    wantBoot = 0;
  endtask

  task automatic drain();
    while (q.size() > 0) cyc();
    cyc();
    cyc();
  endtask

  task automatic readWord(logic [5:0] a);
    wantRd = 1; wantAddr = a;
    cyc();
    drain();
  endtask

  initial begin
    #800us;
    failures++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int w = 0; w < 64; w++) img[w] = 16'((w * 16'h1357) ^ 16'hA5C3);
    img[10] = 16'h2301; img[11] = 16'h6745; img[12] = 16'hAB89;
    // R1: reset state held for a few cycles
    repeat (3) cyc();
    rstN = 1;
    cyc();

    curTest = "R2 R3 R4 R5 read 0x2A phase 2"; curP = 2;
    readWord(6'h2A);
    curTest = "R3 R4 read 0x15 phase 1"; curP = 1;
    readWord(6'h15);
    curTest = "R3 R4 read address 0"; readWord(6'h00);
    curTest = "R3 R4 read address 63"; readWord(6'h3F);

    curTest = "R6 start while busy ignored"; curP = 2;
    wantRd = 1; wantAddr = 6'h05; cyc();
    repeat (20) cyc();
    wantRd = 1; wantAddr = 6'h09; cyc();
    while (q.size() > 1) cyc();
    wantRd = 1; wantAddr = 6'h0C; cyc();
    drain();

    curTest = "R7 phaseLen zero acts as one"; curP = 0;
    readWord(6'h11);
    curTest = "R7 phaseLen change mid-read ignored"; curP = 3;
    wantRd = 1; wantAddr = 6'h22; cyc();
    repeat (10) cyc();
    curP = 1;
    drain();

    curTest = "R8 R9 R10 boot load"; curP = 1;
    wantBoot = 1; cyc();
    repeat (30) cyc();
    wantRd = 1; wantAddr = 6'h01; cyc();
    repeat (200) cyc();
    curTest = "R12 bootStart while busy ignored";
    wantBoot = 1; cyc();
    curTest = "R8 R9 R10 boot load";
    drain();

    curTest = "R11 word0 all ones"; img[0] = 16'hFFFF;
    wantBoot = 1; cyc(); drain();
    curTest = "R11 word0 all zeros"; img[0] = 16'h0000; curP = 2;
    wantBoot = 1; cyc(); drain();

    curTest = "R12 both strobes same cycle"; img[0] = 16'h1234; curP = 1;
    wantBoot = 1; wantRd = 1; wantAddr = 6'h07; cyc();
    while (q.size() > 1) cyc();
    curTest = "R9 read accepted in bootDone cycle";
    wantRd = 1; wantAddr = 6'h0B; cyc();
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule